// File: doc/BRIEF.md
# Duty-Cycled Wake Sequencer

This controller runs in a system that turns its own supply off between short wake-ups. The count of completed wake-ups is kept outside the logic, in charge-storage cells that survive power loss. On each power-up the sequencer reads that stored count. On most wake-ups it adds one to the count, writes the new value back through tri-state count pins during a timed save window and then releases its hold on the supply switch. When the stored count has reached its terminal value it instead raises an enable for an external sample-and-transmit task. It waits for that task to report completion, writes back zero so the sequence starts again, and then powers down.

A start switch gives a second path. If the start input is high when the logic comes up, the stored count is ignored and the internal register is cleared. When the switch is released, the task enable is raised. The hold-power and charge pins are driven from power-up until the end of the save window. After that every pin is released, and the logic stays quiet until its next power-on reset.

Top module: `wake_seq_ctrl`

## Requirements
- R1: While reset is low, and at every cycle before power-down, hold-power is driven low (hold_pwr_oe_o=1, hold_pwr_o=0) and charge is driven high (charge_oe_o=1, charge_o=1). During reset task_en_o=0 and cnt_oe_o=0.
- R2: If start_i is high at the first cycle after reset, the stored count is ignored and the register is cleared. Once start_i falls, task_en_o rises, and the value later written back is 0.
- R3: Without start, a stored count below the terminal value 2**CNT_W-1 (7 for 3 bits) leads to a write-back of count+1, and task_en_o never rises.
- R4: Without start, a stored count equal to the terminal value raises task_en_o, and the value written back afterwards is 0.
- R5: task_en_o stays high until task_done_i has been seen low and is then seen high. A high done that no low preceded does not end the task. The cycle in which done is seen high after the low is the last enable cycle, and the save window follows immediately.
- R6: The save window lasts exactly SAVE_CYCLES consecutive cycles. In it all bits of cnt_oe_o are 1 and cnt_o is stable. Outside it all bits of cnt_oe_o are 0.
- R7: After the save window, hold_pwr_oe_o, charge_oe_o and cnt_oe_o are all 0 and task_en_o is 0. They stay that way whatever start_i, task_done_i and stored_cnt_i do, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the logic |
| start_i | input | 1 | Start switch; clears the count and forces a task run |
| task_done_i | input | 1 | Completion level from the sample-and-transmit task |
| stored_cnt_i | input | CNT_W | Count read from the external storage cells |
| task_en_o | output | 1 | Enable for the sample-and-transmit task |
| hold_pwr_o | output | 1 | Hold-power pin value (low keeps the supply on) |
| hold_pwr_oe_o | output | 1 | Drive enable for hold-power |
| charge_o | output | 1 | Charge pin value for the RC timer |
| charge_oe_o | output | 1 | Drive enable for charge |
| cnt_o | output | CNT_W | Count value written back to storage |
| cnt_oe_o | output | CNT_W | Per-bit drive enables for the count pins |

## Verification
The bench builds the block with CNT_W=3 and a shortened SAVE_CYCLES=12, so that a whole wake-up fits in a few dozen cycles. The narrow count makes the sweep over all eight stored values exhaustive, and that sweep reaches both the wrap to zero and the terminal value. The short window lets every power cycle run to its terminal power-down state. Extra runs cover both start-switch cases and both idle levels of the done input.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_CLEAR,
    ST_SAMPLE,
    ST_BUMP,
    ST_TASK,
    ST_SAVE,
    ST_OFF
  } wake_state_e;

  // terminal count for a given width: all ones
  function automatic logic is_terminal(input logic [7:0] c, input int w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    return c == top;
  endfunction

  // next stored value: wraps to zero after the terminal count
  function automatic logic [7:0] next_count(input logic [7:0] c, input int w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    return (c == top) ? 8'd0 : c + 8'd1;
  endfunction

endpackage

// File: rtl/wake_save_timer.sv
module wake_save_timer #(
  parameter int SAVE_CYCLES = 440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int TW = $clog2(SAVE_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(SAVE_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/wake_done_edge.sv
module wake_done_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic done_i,
  output logic rise_o
);
  logic seen_low_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i) seen_low_q <= 1'b0;
    else if (!done_i)     seen_low_q <= 1'b1;
  end

  assign rise_o = arm_i && seen_low_q && done_i;
endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SAVE_CYCLES = 440
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             task_done_i,
  input  logic [CNT_W-1:0] stored_cnt_i,
  output logic             task_en_o,
  output logic             hold_pwr_o,
  output logic             hold_pwr_oe_o,
  output logic             charge_o,
  output logic             charge_oe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_oe_o
);
  wake_state_e      state_q, state_d;
  logic [CNT_W-1:0] reg_q, reg_d;

  // named internal events, used by the bound checker
  logic in_save, in_task, powered, save_last, done_rise, stored_top;

  assign in_save    = (state_q == ST_SAVE);
  assign in_task    = (state_q == ST_TASK);
  assign powered    = (state_q != ST_OFF);
  assign stored_top = is_terminal(8'(stored_cnt_i), CNT_W);

  wake_save_timer #(.SAVE_CYCLES(SAVE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(in_save), .last_o(save_last)
  );

  wake_done_edge u_edge (
    .clk(clk), .rst_n(rst_n), .arm_i(in_task),
    .done_i(task_done_i), .rise_o(done_rise)
  );

  always_comb begin
    state_d = state_q;
    reg_d   = reg_q;
    unique case (state_q)
      ST_PWRUP:  state_d = start_i ? ST_CLEAR : ST_SAMPLE;
      ST_CLEAR: begin
        reg_d = '0;
        if (!start_i) state_d = ST_TASK;
      end
      ST_SAMPLE: begin
        if (stored_top) begin
          reg_d   = '0;
          state_d = ST_TASK;
        end else begin
          reg_d   = stored_cnt_i;
          state_d = ST_BUMP;
        end
      end
      ST_BUMP: begin
        reg_d   = CNT_W'(next_count(8'(reg_q), CNT_W));
        state_d = ST_SAVE;
      end
      ST_TASK:  if (done_rise) state_d = ST_SAVE;
      ST_SAVE:  if (save_last) state_d = ST_OFF;
      ST_OFF:   state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      reg_q   <= '0;
    end else begin
      state_q <= state_d;
      reg_q   <= reg_d;
    end
  end

  assign task_en_o     = in_task;
  assign hold_pwr_o    = 1'b0;
  assign hold_pwr_oe_o = powered;
  assign charge_o      = 1'b1;
  assign charge_oe_o   = powered;
  assign cnt_o         = reg_q;
  assign cnt_oe_o      = {CNT_W{in_save}};
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int CNT_W       = 3,
  parameter int SAVE_CYCLES = 440
) (
  input logic             clk,
  input logic             rst_n,
  input logic             task_en_o,
  input logic             hold_pwr_oe_o,
  input logic             charge_oe_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cnt_oe_o,
  input logic             save_last
);
  logic [31:0] run_len;
  logic        save_on;

  assign save_on = &cnt_oe_o;

  always_ff @(posedge clk) begin
    if (!rst_n || !save_on) run_len <= '0;
    else                    run_len <= run_len + 1;
  end

  // R6: window length counted independently of the design's timer
  assert_save_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_on) |-> run_len == 32'(SAVE_CYCLES));

  // R6: written value held for the whole window
  assert_save_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_on && $past(save_on)) |-> $stable(cnt_o));

  // R6: count enables are all-or-nothing
  assert_oe_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_oe_o == '0) || save_on);

  // R5: enable falls only into the save window
  assert_task_to_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(task_en_o) |-> save_on);

  // R4: after a task run the written value is zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(save_on) && $past(task_en_o)) |-> cnt_o == '0);

  // R7: once released, every pin stays released
  assert_off_terminal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_pwr_oe_o) |=> (!hold_pwr_oe_o && !charge_oe_o && cnt_oe_o == '0 && !task_en_o));

  // R7: power is released right after the timer's last cycle
  assert_release_after_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    save_last |=> !hold_pwr_oe_o);

  // R1: supply pins move together
  assert_pins_paired_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pwr_oe_o == charge_oe_o);
endmodule

bind wake_seq_ctrl wake_seq_chk #(.CNT_W(CNT_W), .SAVE_CYCLES(SAVE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_en_o(task_en_o), .hold_pwr_oe_o(hold_pwr_oe_o),
  .charge_oe_o(charge_oe_o), .cnt_o(cnt_o), .cnt_oe_o(cnt_oe_o), .save_last(save_last)
);

// File: tb/test_wake_seq_ctrl.sv
module test_wake_seq_ctrl;
  localparam int W    = 3;
  localparam int SAVE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic task_done_i = 1'b1;
  logic [W-1:0] stored_cnt_i = '0;
  logic task_en_o, hold_pwr_o, hold_pwr_oe_o, charge_o, charge_oe_o;
  logic [W-1:0] cnt_o, cnt_oe_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wake_seq_ctrl #(.CNT_W(W), .SAVE_CYCLES(SAVE)) i_wake_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .task_done_i(task_done_i),
    .stored_cnt_i(stored_cnt_i), .task_en_o(task_en_o), .hold_pwr_o(hold_pwr_o),
    .hold_pwr_oe_o(hold_pwr_oe_o), .charge_o(charge_o), .charge_oe_o(charge_oe_o),
    .cnt_o(cnt_o), .cnt_oe_o(cnt_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full wake-up: reset, run until power release, then probe the off state
  task automatic power_cycle(input int stored, input int start_cyc, input bit idle_done,
                             input int a, input int b, input int exp_en, input int exp_wb);
    int en_cnt = 0, save_cnt = 0, wb = -1, cyc = 0;
    bit pin_bad = 0, off = 0, off_bad = 0;
    @(negedge clk);
    rst_n = 1'b0;
    stored_cnt_i = W'(stored);
    start_i = (start_cyc > 0);
    task_done_i = idle_done;
    @(negedge clk);
    @(negedge clk);
    check(hold_pwr_oe_o && !hold_pwr_o && charge_oe_o && charge_o && !task_en_o && cnt_oe_o == '0,
          "R1 reset state", int'({hold_pwr_oe_o, hold_pwr_o, charge_oe_o, charge_o, task_en_o}), 5'b10110);
    rst_n = 1'b1;
    while (cyc < 500 && !off) begin
      @(negedge clk);
      cyc++;
      if (cyc >= start_cyc) start_i = 1'b0;
      if (!hold_pwr_oe_o) off = 1;
      else begin
        if (hold_pwr_o || !charge_oe_o || !charge_o) pin_bad = 1;
        if (task_en_o) begin
          en_cnt++;
          task_done_i = (en_cnt < a) ? idle_done : ((en_cnt < b) ? 1'b0 : 1'b1);
        end
        if (cnt_oe_o == '1) begin
          save_cnt++;
          wb = int'(cnt_o);
        end else if (cnt_oe_o != '0) pin_bad = 1;
      end
    end
    check(!pin_bad, "R1 supply pins held while powered", int'(pin_bad), 0);
    check(en_cnt == exp_en, (exp_en == 0) ? "R3 no enable" : "R5 enable length", en_cnt, exp_en);
    check(wb == exp_wb, (start_cyc > 0) ? "R2 cleared write-back" :
          ((exp_en > 0) ? "R4 wrap write-back" : "R3 incremented write-back"), wb, exp_wb);
    check(save_cnt == SAVE, "R6 save window length", save_cnt, SAVE);
    check(off, "R7 power released", int'(off), 1);
    for (int k = 0; k < 16; k++) begin
      start_i = k[0];
      task_done_i = k[1];
      stored_cnt_i = W'(k);
      @(negedge clk);
      if (hold_pwr_oe_o || charge_oe_o || cnt_oe_o != '0 || task_en_o) off_bad = 1;
    end
    check(!off_bad, "R7 off state terminal", int'(off_bad), 0);
    start_i = 1'b0;
  endtask

  initial begin
    // R3/R4: every stored value, done idling high (early high must not end the task, R5)
    for (int s = 0; s < 8; s++) begin
      int top = (1 << W) - 1;
      power_cycle(s, 0, 1'b1, 3, 6, (s == top) ? 6 : 0, (s == top) ? 0 : s + 1);
    end
    // R5: done idling low
    power_cycle(7, 0, 1'b0, 2, 4, 4, 0);
    // R2: start switch held at power-up, stored value ignored
    power_cycle(3, 4, 1'b1, 2, 5, 5, 0);
    power_cycle(7, 6, 1'b0, 1, 3, 3, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule